// File: doc/BRIEF.md
# Multi-Bank SRAM Zero-Fill Sequencer

This block wipes whole SRAM banks to zero on request. Software writes a request word in which each bit names one bank. The sequencer then owns a single-word SRAM write port and writes an all-zero word to every address of each named bank. It walks through the banks one after another, from the lowest bank index upward. Each bank has its own fixed size, and the banks lie back to back in one word-address space starting at address 0.

A grant input from the memory arbiter gates progress. In each cycle the grant is high and a bank is active, exactly one zero word is written. When grant is low, the port is idle and the address holds.

Each request bit clears itself once the last word of its bank has been written, and busy stays high while any bit is still pending. A one-cycle done pulse marks the moment the pending set empties. Requests written while the sequencer is busy join the pending set. They never restart the bank that is currently being wiped.

Top module: `zq_zeroize_seq`

## Requirements
- R1: After reset, the pending request bits are 0, busy is 0, done is 0 and no SRAM write is issued.
- R2: A request write ORs req_bits into the pending set. Bit k selects bank k, and any combination of bits in one write clears every bank selected.
- R3: With default parameters, the banks are 8192, 8192, 12288 and 4096 words of 32 bits (32, 32, 48 and 16 KiB). They lie contiguously at word bases 0, 8192, 16384 and 28672, so bank k covers every address from its base up to its base plus its size minus one.
- R4: When a bank finishes, the next bank wiped is the lowest-numbered pending bank. Addresses inside a bank rise by one per write.
- R5: A write (mem_we high) happens only in a cycle where mem_grant is high. While grant is low, mem_addr holds its value.
- R6: A bank's pending bit drops to 0 on the clock edge that writes the bank's last word, unless the same bit is requested in that same cycle.
- R7: busy is high exactly while at least one pending bit is set.
- R8: A request write during busy is merged into the pending set. The bank being wiped is not restarted, and its word sequence continues without a gap or repeat.
- R9: done is high for exactly one cycle, in the cycle after the pending set becomes empty through a bank completion.
- R10: mem_wdata is all zeros for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_we | input | 1 | Request register write strobe |
| req_bits | input | NUM_BANKS | Bank select bits to add to the pending set |
| mem_grant | input | 1 | Arbiter grant for the SRAM write port |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | DATA_W | SRAM write data (always zero) |
| mem_we | output | 1 | SRAM write enable |
| req_pending | output | NUM_BANKS | Pending request bits |
| busy | output | 1 | High while any request is pending |
| done | output | 1 | One-cycle pulse when the pending set empties |

## Verification
The assertions take for granted that reset is held for at least one clock edge, and that mem_grant and the request inputs are stable around each rising edge. The address-hold check also assumes that grant may drop at any point inside a bank, including on the last word. The stimulus drives every input one time step after the rising edge. It toggles grant in a fixed pattern during one whole bank. It issues a merge write while a bank is mid-way through, re-requesting that bank together with a higher one, so that a restart would show up as a repeated address in the scoreboard.

// File: rtl/zq_pkg.sv
package zq_pkg;
   // Number of data words needed to cover a bank of the given size in KiB.
   function automatic int unsigned kib_to_words(int unsigned kib, int unsigned data_w);
      return (kib * 1024 * 8) / data_w;
   endfunction
endpackage

// File: rtl/zq_req_reg.sv
module zq_req_reg #(
   parameter int unsigned NB = 4,
   parameter int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [NB-1:0] wr_bits,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx,
   output logic [NB-1:0] pending,
   output logic          done
);
   logic [NB-1:0] clr_mask;
   logic [NB-1:0] pending_nxt;

   always_comb begin
      clr_mask    = clr_en ? (NB'(1) << clr_idx) : '0;
      // a new request of the same bit wins over its completion
      pending_nxt = (pending & ~clr_mask) | (wr_en ? wr_bits : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= '0;
         done    <= 1'b0;
      end else begin
         pending <= pending_nxt;
         done    <= (|pending) && (pending_nxt == '0);
      end
   end

   // R8: written bits are present in the pending set on the next cycle
   a_r8_merge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((pending & $past(wr_bits)) == $past(wr_bits)));
   // R9: done only with an empty pending set
   a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pending == '0));
   // R9: the pending set emptying always produces done
   a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|pending) |-> done);
endmodule

// File: rtl/zq_pick_lowest.sv
module zq_pick_lowest #(
   parameter int unsigned NB = 4,
   parameter int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic [NB-1:0] mask,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = |mask;
      idx   = '0;
      for (int i = NB - 1; i >= 0; i--) begin
         if (mask[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/zq_addr_gen.sv
module zq_addr_gen #(
   parameter int unsigned NB = 4,
   parameter int unsigned AW = 15,
   parameter int unsigned BANK_WORDS [NB] = '{8192, 8192, 12288, 4096},
   parameter int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] start_idx,
   input  logic          step,
   output logic          active,
   output logic [IW-1:0] cur_idx,
   output logic [AW-1:0] addr,
   output logic          last
);
   function automatic int unsigned base_of(int unsigned k);
      int unsigned s = 0;
      for (int unsigned i = 0; i < k; i++) s += BANK_WORDS[i];
      return s;
   endfunction

   logic [AW-1:0] base_lut [NB];
   logic [AW-1:0] end_lut  [NB];
   logic [AW-1:0] off;

   for (genvar g = 0; g < NB; g++) begin : g_lut
      assign base_lut[g] = AW'(base_of(g));
      assign end_lut[g]  = AW'(BANK_WORDS[g] - 1);
   end

   assign addr = base_lut[cur_idx] + off;
   assign last = (off == end_lut[cur_idx]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cur_idx <= '0;
         off     <= '0;
      end else if (start && !active) begin
         active  <= 1'b1;
         cur_idx <= start_idx;
         off     <= '0;
      end else if (step && active) begin
         if (last) active <= 1'b0;
         else      off    <= off + 1'b1;
      end
   end

   // R4: consecutive words of a bank are at consecutive addresses
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && active && !last) |=> (addr == $past(addr) + 1'b1));
   // R5: without a step the address holds
   a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !step) |=> (active && $stable(addr)));
   // R8: the active bank is never swapped before its last word
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !(step && last)) |=> (active && $stable(cur_idx)));
endmodule

// File: rtl/zq_zeroize_seq.sv
module zq_zeroize_seq #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned BANK_WORDS [NUM_BANKS] = '{
      zq_pkg::kib_to_words(32, DATA_W), zq_pkg::kib_to_words(32, DATA_W),
      zq_pkg::kib_to_words(48, DATA_W), zq_pkg::kib_to_words(16, DATA_W)}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_we,
   input  logic [NUM_BANKS-1:0] req_bits,
   input  logic                 mem_grant,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic                 mem_we,
   output logic [NUM_BANKS-1:0] req_pending,
   output logic                 busy,
   output logic                 done
);
   localparam int unsigned IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   function automatic longint unsigned total_words();
      longint unsigned s = 0;
      for (int unsigned i = 0; i < NUM_BANKS; i++) s += BANK_WORDS[i];
      return s;
   endfunction

   initial begin
      assert (NUM_BANKS >= 1) else $error("NUM_BANKS must be at least 1");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (total_words() <= (64'd1 << ADDR_W)) else $error("ADDR_W too narrow for the banks");
      for (int unsigned i = 0; i < NUM_BANKS; i++)
         assert (BANK_WORDS[i] > 0) else $error("bank %0d has zero size", i);
   end

   logic          found, active, last;
   logic [IW-1:0] pick_idx, cur_idx;

   zq_pick_lowest #(.NB(NUM_BANKS), .IW(IW)) u_pick (
      .mask (req_pending),
      .found(found),
      .idx  (pick_idx)
   );

   zq_addr_gen #(.NB(NUM_BANKS), .AW(ADDR_W), .BANK_WORDS(BANK_WORDS), .IW(IW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (found && !active),
      .start_idx(pick_idx),
      .step     (mem_we),
      .active   (active),
      .cur_idx  (cur_idx),
      .addr     (mem_addr),
      .last     (last)
   );

   zq_req_reg #(.NB(NUM_BANKS), .IW(IW)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (req_we),
      .wr_bits(req_bits),
      .clr_en (mem_we && last),
      .clr_idx(cur_idx),
      .pending(req_pending),
      .done   (done)
   );

   assign mem_we    = active && mem_grant;
   assign mem_wdata = '0;
   assign busy      = |req_pending;

   // R6: completing a bank drops its bit unless re-requested in the same cycle
   a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && last && !(req_we && req_bits[cur_idx])) |=> !req_pending[$past(cur_idx)]);
   // R2: any pending bank is taken up on the next cycle when idle
   a_r2_serve: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !active) |=> active);
   // R7: an active bank always has its pending bit set
   a_r7_active_pending: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> req_pending[cur_idx]);
endmodule

// File: tb/tb_zq_zeroize_seq.sv
module tb_zq_zeroize_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_we = 1'b0;
   logic [3:0]  req_bits = '0;
   logic        mem_grant = 1'b1;
   logic [14:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_we;
   logic [3:0]  req_pending;
   logic        busy, done;

   always #5 clk = ~clk;

   zq_zeroize_seq dut (
      .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_bits(req_bits),
      .mem_grant(mem_grant), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .req_pending(req_pending), .busy(busy), .done(done)
   );

   // expected layout (R3)
   int unsigned bank_base [4] = '{0, 8192, 16384, 28672};
   int unsigned bank_size [4] = '{8192, 8192, 12288, 4096};

   int unsigned exp_q [$];
   int checks = 0, errors = 0;
   int mism = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;
   bit grant_toggle = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push_bank(input int k);
      for (int i = 0; i < int'(bank_size[k]); i++) exp_q.push_back(bank_base[k] + i);
   endtask

   // grant driver
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 mem_grant = grant_toggle ? ((cyc % 3) != 0) : 1'b1;
   end

   // monitor: pop and compare each write
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_cnt++;
         if (mem_we) begin
            wr_cnt++;
            if (!mem_grant) mism++;
            if (mem_wdata != 0) mism++;
            if (exp_q.size() == 0) mism++;
            else if (int'(mem_addr) != int'(exp_q.pop_front())) mism++;
         end
      end
   end

   task automatic issue(input logic [3:0] bits);
      @(posedge clk); #1;
      req_we = 1'b1; req_bits = bits;
      @(posedge clk); #1;
      req_we = 1'b0; req_bits = '0;
   endtask

   task automatic finish_run(input string req, input string name);
      do @(negedge clk); while (busy);
      @(negedge clk);
      check(mism == 0, req, {name, " scoreboard mismatches"}, mism, 0);
      check(exp_q.size() == 0, req, {name, " words left unwritten"}, exp_q.size(), 0);
      check(done_cnt == 1, "R9", {name, " done pulses"}, done_cnt, 1);
      check(req_pending == 0, "R6", {name, " pending after finish"}, req_pending, 0);
      mism = 0; done_cnt = 0; wr_cnt = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(req_pending == 0, "R1", "pending in reset", req_pending, 0);
      check(busy == 0, "R1", "busy in reset", busy, 0);
      check(mem_we == 0, "R1", "mem_we in reset", mem_we, 0);
      check(done == 0, "R1", "done in reset", done, 0);
      rst_n = 1'b1;

      // single small bank (R2, R3, R7, R10)
      push_bank(3);
      issue(4'b1000);
      check(req_pending == 4'b1000, "R2", "pending after write", req_pending, 4'b1000);
      check(busy == 1, "R7", "busy while pending", busy, 1);
      finish_run("R3", "bank3");
      check(busy == 0, "R7", "busy after finish", busy, 0);

      // bank 2 with grant gaps (R5)
      grant_toggle = 1'b1;
      push_bank(2);
      issue(4'b0100);
      finish_run("R5", "bank2 stalled");
      grant_toggle = 1'b0;

      // two banks in one write, ascending order (R4)
      push_bank(0); push_bank(2);
      issue(4'b0101);
      finish_run("R4", "banks0+2");

      // merge while busy, no restart (R8)
      push_bank(1); push_bank(3);
      issue(4'b0010);
      while (wr_cnt < 100) @(negedge clk);
      issue(4'b1010);
      check(req_pending == 4'b1010, "R8", "pending after merge", req_pending, 4'b1010);
      finish_run("R8", "merge");

      // all four banks, self-clear of bank 0 (R6, R2)
      for (int k = 0; k < 4; k++) push_bank(k);
      issue(4'b1111);
      while (wr_cnt < 8192 + 10) @(negedge clk);
      check(req_pending == 4'b1110, "R6", "bank0 bit cleared", req_pending, 4'b1110);
      finish_run("R2", "all banks");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule